// File: doc/BRIEF.md
# OTP Memory Page-Access Controller

This block gives software register access to a one-time-programmable style memory of 512 pages of 128 bits each. Here the array is ordinary writable storage. Software fills four 32-bit data words and a 16-bit byte mask, then writes a control word. The control word carries a page number and a program command and/or a fetch command. The controller moves the enabled bytes between the data words and the chosen page in the same clock edge. It then raises a done flag in a status register that software clears by writing one.

Every register accepts one access width only: 16-bit or 32-bit. An access with the wrong width, or to an offset that maps to no register, pulses an error output and leaves all state unchanged. Read data and the error pulse are registered. Both appear one cycle after the request.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, the byte mask reads 0xFFFF, the timing word reads 0x00001485, and both the control and status registers read 0.
- R2: The registers are control at 0x00, byte mask at 0x04, status at 0x08, timing at 0x0C, and data words 0 to 3 at 0x80, 0x84, 0x88 and 0x8C. `size_i` = 2'b01 is a 16-bit access and 2'b10 is a 32-bit access. Control, mask and status take 16-bit accesses and read back zero-extended. Timing and the data words take 32-bit accesses.
- R3: An access of the wrong width, an access with any other `size_i` value, or an access to any other offset sets `err_o` for one cycle, one cycle after the request. No register or page changes, and `rdata_o` is 0. A valid access leaves `err_o` low.
- R4: A control write stores its 16-bit value ANDed with 0x39FF, and that stored value reads back.
- R5: In a control write, bit 15 is the program command. It writes the 128-bit value {data3,data2,data1,data0} (data0 least significant) into the page selected by bits 8:0. Only the bytes i whose mask bit i is 1 are written.
- R6: In a control write, bit 14 is the fetch command. It copies byte i of the selected page into byte i of the data words wherever mask bit i is 1. The other data bytes keep their values.
- R7: When bits 15 and 14 are both set, the program happens first. The page then holds the new bytes and the data words are unchanged.
- R8: Every valid control write sets status bit 0 (done), including a write with no command bit set.
- R9: Status is write-one-to-clear. Writing 1 to bit 0 clears done. Writing 0 leaves it unchanged.
- R10: All bits of the byte mask, the timing word and the data words are writable and read back as written.
- R11: Read data for a valid read appears on `rdata_o` in the cycle after `re_i` and is 0 in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write request |
| re_i | input | 1 | Read request |
| size_i | input | 2 | Access width: 01 = 16-bit, 10 = 32-bit |
| wdata_i | input | 32 | Write data; 16-bit registers use bits 15:0 |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse for an invalid access |

## Verification
The assertions assume at most one request per cycle. They also assume the request inputs are stable around the rising edge. They rebuild the width rule from the offset and `size_i` and compare it with the error pulse and with the register state one cycle later. The bench drives every request on the falling edge and holds it for one full cycle. It never asserts `we_i` and `re_i` together, so every access falls under exactly one of the checked rules.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned PAGE_WORDS = 4;
  localparam int unsigned PAGE_BITS  = PAGE_WORDS * WORD_W;
  localparam int unsigned PAGE_BYTES = PAGE_BITS / 8;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [15:0] CTRL_KEEP  = 16'h39FF;
  localparam int unsigned CMD_WR_BIT = 15;
  localparam int unsigned CMD_RD_BIT = 14;
  localparam int unsigned DONE_BIT   = 0;
  localparam logic [31:0] TIMING_RST = 32'h0000_1485;
  localparam logic [15:0] BEN_RST    = 16'hFFFF;

  typedef enum logic [3:0] {
    REG_CTRL, REG_BEN, REG_STAT, REG_TIME,
    REG_D0, REG_D1, REG_D2, REG_D3, REG_NONE
  } reg_e;
endpackage

// File: rtl/otp_access_check.sv
module otp_access_check
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              req_i,
  output reg_e              sel_o,
  output logic              hit_o,
  output logic              miss_o
);
  logic [1:0] need;

  always_comb begin
    case (addr_i)
      ADDR_W'(8'h00): sel_o = REG_CTRL;
      ADDR_W'(8'h04): sel_o = REG_BEN;
      ADDR_W'(8'h08): sel_o = REG_STAT;
      ADDR_W'(8'h0C): sel_o = REG_TIME;
      ADDR_W'(8'h80): sel_o = REG_D0;
      ADDR_W'(8'h84): sel_o = REG_D1;
      ADDR_W'(8'h88): sel_o = REG_D2;
      ADDR_W'(8'h8C): sel_o = REG_D3;
      default:        sel_o = REG_NONE;
    endcase
    need = (sel_o == REG_CTRL || sel_o == REG_BEN || sel_o == REG_STAT) ? SZ_HALF : SZ_WORD;
  end

  assign hit_o  = req_i && (sel_o != REG_NONE) && (size_i == need);
  assign miss_o = req_i && !hit_o;
endmodule

// File: rtl/otp_page_store.sv
module otp_page_store
  import otp_pkg::*;
#(
  parameter int unsigned PAGES  = 512,
  parameter int unsigned PAGE_W = $clog2(PAGES)
) (
  input  logic                  clk_i,
  input  logic                  wr_en_i,
  input  logic [PAGE_W-1:0]     page_i,
  input  logic [PAGE_BYTES-1:0] ben_i,
  input  logic [PAGE_BITS-1:0]  wdata_i,
  output logic [PAGE_BITS-1:0]  rdata_o
);
  logic [PAGE_BITS-1:0] mem [PAGES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < int'(PAGE_BYTES); b++) begin
        if (ben_i[b]) mem[page_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign rdata_o = mem[page_i];
endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned PAGES  = 512,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  localparam int unsigned PAGE_W = $clog2(PAGES);

  reg_e                  sel;
  logic                  hit, miss, wr_ok, rd_ok;
  logic                  ctrl_wr, cmd_wr, cmd_rd;
  logic [PAGE_W-1:0]     page;
  logic [HALF_W-1:0]     ctrl_q, ben_q, stat_q;
  logic [WORD_W-1:0]     timing_q;
  logic [WORD_W-1:0]     data_q [PAGE_WORDS];
  logic [PAGE_BITS-1:0]  wvec, page_rd, rd_merge;
  logic [31:0]           rdata_q, rd_val;
  logic                  err_q;

  otp_access_check #(.ADDR_W(ADDR_W)) u_check (
    .addr_i (addr_i),
    .size_i (size_i),
    .req_i  (we_i | re_i),
    .sel_o  (sel),
    .hit_o  (hit),
    .miss_o (miss)
  );

  assign wr_ok   = hit & we_i;
  assign rd_ok   = hit & re_i & ~we_i;
  assign ctrl_wr = wr_ok && (sel == REG_CTRL);
  assign cmd_wr  = ctrl_wr & wdata_i[CMD_WR_BIT];
  assign cmd_rd  = ctrl_wr & wdata_i[CMD_RD_BIT];
  assign page    = wdata_i[PAGE_W-1:0];

  otp_page_store #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_store (
    .clk_i   (clk_i),
    .wr_en_i (cmd_wr),
    .page_i  (page),
    .ben_i   (ben_q),
    .wdata_i (wvec),
    .rdata_o (page_rd)
  );

  // fetch source: freshly programmed bytes win over array contents
  always_comb begin
    for (int b = 0; b < int'(PAGE_BYTES); b++) begin
      rd_merge[8*b +: 8] = ben_q[b] ? (cmd_wr ? wvec[8*b +: 8] : page_rd[8*b +: 8])
                                    : wvec[8*b +: 8];
    end
  end

  for (genvar w = 0; w < int'(PAGE_WORDS); w++) begin : g_data
    assign wvec[WORD_W*w +: WORD_W] = data_q[w];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      data_q[w] <= '0;
      else if (cmd_rd)                                  data_q[w] <= rd_merge[WORD_W*w +: WORD_W];
      else if (wr_ok && sel == reg_e'(REG_D0 + 4'(w))) data_q[w] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ben_q    <= BEN_RST;
      stat_q   <= '0;
      timing_q <= TIMING_RST;
    end else if (wr_ok) begin
      case (sel)
        REG_CTRL: begin
          ctrl_q           <= wdata_i[HALF_W-1:0] & CTRL_KEEP;
          stat_q[DONE_BIT] <= 1'b1;
        end
        REG_BEN:  ben_q    <= wdata_i[HALF_W-1:0];
        REG_STAT: stat_q   <= stat_q & ~wdata_i[HALF_W-1:0];
        REG_TIME: timing_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL: rd_val = {16'h0, ctrl_q};
      REG_BEN:  rd_val = {16'h0, ben_q};
      REG_STAT: rd_val = {16'h0, stat_q};
      REG_TIME: rd_val = timing_q;
      REG_D0:   rd_val = data_q[0];
      REG_D1:   rd_val = data_q[1];
      REG_D2:   rd_val = data_q[2];
      REG_D3:   rd_val = data_q[3];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_ok ? rd_val : '0;
      err_q   <= miss;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/otp_page_ctrl_sva.sv
module otp_page_ctrl_sva #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [1:0]        size_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [15:0]       ctrl_q,
  input logic [15:0]       ben_q,
  input logic [15:0]       stat_q,
  input logic [31:0]       timing_q
);
  logic is_half, is_word, good, bad, req;

  always_comb begin
    is_half = (addr_i == ADDR_W'(8'h00)) || (addr_i == ADDR_W'(8'h04)) || (addr_i == ADDR_W'(8'h08));
    is_word = (addr_i == ADDR_W'(8'h0C)) || (addr_i == ADDR_W'(8'h80)) || (addr_i == ADDR_W'(8'h84))
           || (addr_i == ADDR_W'(8'h88)) || (addr_i == ADDR_W'(8'h8C));
    req  = we_i | re_i;
    good = (is_half && size_i == 2'b01) || (is_word && size_i == 2'b10);
    bad  = req && !good;
  end

  assert_bad_flags_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> err_o);
  assert_good_no_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && good) |=> !err_o);
  assert_bad_keeps_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> ($stable(ctrl_q) && $stable(ben_q) && $stable(stat_q) && $stable(timing_q)));
  assert_ctrl_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && good && addr_i == ADDR_W'(8'h00)) |=> (ctrl_q == ($past(wdata_i[15:0]) & 16'h39FF)));
  assert_ctrl_sets_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && good && addr_i == ADDR_W'(8'h00)) |=> stat_q[0]);
  assert_w1c_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && good && addr_i == ADDR_W'(8'h08) && wdata_i[0]) |=> !stat_q[0]);
  assert_half_zext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i && good && is_half) |=> (rdata_o[31:16] == 16'h0));
  assert_idle_rdata_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == 32'h0));
endmodule

bind otp_page_ctrl otp_page_ctrl_sva #(.ADDR_W(ADDR_W)) sva_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .size_i   (size_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .err_o    (err_o),
  .ctrl_q   (ctrl_q),
  .ben_q    (ben_q),
  .stat_q   (stat_q),
  .timing_q (timing_q)
);

// File: tb/otp_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_page_ctrl_tb_top;
  localparam logic [1:0] H = 2'b01;
  localparam logic [1:0] W = 2'b10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  otp_page_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk_i);
    addr_i = a; size_i = sz; wdata_i = wd; we_i = wr; re_i = ~wr;
    @(negedge clk_i);
    rd = rdata_o; er = err_o;
    we_i = 1'b0; re_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd, input string req);
    logic [31:0] rd; logic er;
    acc(1'b1, a, sz, wd, rd, er);
    chk(req, {31'h0, er}, 32'h0);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic er;
    acc(1'b0, a, sz, 32'h0, rd, er);
    chk(req, rd, exp);
    chk(req, {31'h0, er}, 32'h0);
  endtask

  task automatic set_data(input logic [31:0] d0, d1, d2, d3);
    wr(8'h80, W, d0, "R10"); wr(8'h84, W, d1, "R10");
    wr(8'h88, W, d2, "R10"); wr(8'h8C, W, d3, "R10");
  endtask

  task automatic exp_data(input logic [31:0] d0, d1, d2, d3, input string req);
    rd_chk(8'h80, W, d0, req); rd_chk(8'h84, W, d1, req);
    rd_chk(8'h88, W, d2, req); rd_chk(8'h8C, W, d3, req);
  endtask

  task automatic t_reset;
    chk("R11_idle", rdata_o, 32'h0);
    rd_chk(8'h04, H, 32'h0000_FFFF, "R1_ben");
    rd_chk(8'h0C, W, 32'h0000_1485, "R1_timing");
    rd_chk(8'h00, H, 32'h0, "R1_ctrl");
    rd_chk(8'h08, H, 32'h0, "R1_stat");
    chk("R11_after", rdata_o, 32'h0);
  endtask

  task automatic t_ctrl_status;
    wr(8'h00, H, 32'hFFFF_3FFF, "R4");
    rd_chk(8'h00, H, 32'h0000_39FF, "R4_mask");
    rd_chk(8'h08, H, 32'h1, "R8_done_nocmd");
    wr(8'h08, H, 32'h0, "R9");
    rd_chk(8'h08, H, 32'h1, "R9_zero_keeps");
    wr(8'h08, H, 32'h1, "R9");
    rd_chk(8'h08, H, 32'h0, "R9_clear");
  endtask

  task automatic t_width_err;
    logic [31:0] rd; logic er;
    acc(1'b1, 8'h04, W, 32'h0, rd, er);
    chk("R3_ben_word", {31'h0, er}, 32'h1);
    rd_chk(8'h04, H, 32'h0000_FFFF, "R3_ben_kept");
    acc(1'b1, 8'h0C, H, 32'h0, rd, er);
    chk("R3_timing_half", {31'h0, er}, 32'h1);
    rd_chk(8'h0C, W, 32'h0000_1485, "R3_timing_kept");
    acc(1'b0, 8'h10, W, 32'h0, rd, er);
    chk("R3_unmapped_err", {31'h0, er}, 32'h1);
    chk("R3_unmapped_rdata", rd, 32'h0);
    acc(1'b0, 8'h80, 2'b00, 32'h0, rd, er);
    chk("R3_byte_size", {31'h0, er}, 32'h1);
    acc(1'b1, 8'h00, W, 32'h0000_8005, rd, er);
    chk("R3_ctrl_word", {31'h0, er}, 32'h1);
    rd_chk(8'h00, H, 32'h0000_39FF, "R3_ctrl_kept");
    rd_chk(8'h08, H, 32'h0, "R3_no_done");
  endtask

  task automatic t_rw_regs;
    wr(8'h0C, W, 32'hDEAD_BEEF, "R10");
    rd_chk(8'h0C, W, 32'hDEAD_BEEF, "R10_timing");
    wr(8'h04, H, 32'h0000_A5C3, "R10");
    rd_chk(8'h04, H, 32'h0000_A5C3, "R10_ben_R2_zext");
    wr(8'h04, H, 32'h0000_FFFF, "R10");
    set_data(32'h0102_0304, 32'hF0F0_0F0F, 32'h8000_0001, 32'h7FFF_FFFE);
    exp_data(32'h0102_0304, 32'hF0F0_0F0F, 32'h8000_0001, 32'h7FFF_FFFE, "R10_data_R2");
  endtask

  task automatic t_page_rw;
    set_data(32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444);
    wr(8'h00, H, 32'h0000_8005, "R5");
    rd_chk(8'h08, H, 32'h1, "R8_after_prog");
    set_data(32'h0, 32'h0, 32'h0, 32'h0);
    wr(8'h00, H, 32'h0000_4005, "R6");
    exp_data(32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444, "R5_R6_full");
  endtask

  task automatic t_masked_prog;
    wr(8'h04, H, 32'h0000_000F, "R5");
    set_data(32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD);
    wr(8'h00, H, 32'h0000_8005, "R5");
    wr(8'h04, H, 32'h0000_FFFF, "R5");
    set_data(32'h0, 32'h0, 32'h0, 32'h0);
    wr(8'h00, H, 32'h0000_4005, "R5");
    exp_data(32'hAAAA_AAAA, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444, "R5_masked");
  endtask

  task automatic t_masked_fetch;
    wr(8'h04, H, 32'h0000_0F00, "R6");
    set_data(32'h5555_5555, 32'h5555_5555, 32'h5555_5555, 32'h5555_5555);
    wr(8'h00, H, 32'h0000_4005, "R6");
    exp_data(32'h5555_5555, 32'h5555_5555, 32'h3333_3333, 32'h5555_5555, "R6_masked");
    wr(8'h04, H, 32'h0000_0181, "R6");
    set_data(32'h0, 32'h0, 32'h0, 32'h0);
    wr(8'h00, H, 32'h0000_4005, "R6");
    exp_data(32'h0000_00AA, 32'h2200_0000, 32'h0000_0033, 32'h0, "R6_bytes");
    wr(8'h04, H, 32'h0000_FFFF, "R6");
  endtask

  task automatic t_both;
    set_data(32'hCAFE_F00D, 32'h0BAD_CAFE, 32'h1234_5678, 32'h9ABC_DEF0);
    wr(8'h00, H, 32'h0000_C007, "R7");
    exp_data(32'hCAFE_F00D, 32'h0BAD_CAFE, 32'h1234_5678, 32'h9ABC_DEF0, "R7_data_kept");
    set_data(32'h0, 32'h0, 32'h0, 32'h0);
    wr(8'h00, H, 32'h0000_4007, "R7");
    exp_data(32'hCAFE_F00D, 32'h0BAD_CAFE, 32'h1234_5678, 32'h9ABC_DEF0, "R7_page");
    set_data(32'h600D_0001, 32'h600D_0002, 32'h600D_0003, 32'h600D_0004);
    wr(8'h00, H, 32'h0000_81FF, "R5");
    set_data(32'h0, 32'h0, 32'h0, 32'h0);
    wr(8'h00, H, 32'h0000_4005, "R5");
    exp_data(32'hAAAA_AAAA, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444, "R5_page_isolated");
    wr(8'h00, H, 32'h0000_41FF, "R6");
    exp_data(32'h600D_0001, 32'h600D_0002, 32'h600D_0003, 32'h600D_0004, "R6_last_page");
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ctrl_status();
    t_width_err();
    t_rw_regs();
    t_page_rw();
    t_masked_prog();
    t_masked_fetch();
    t_both();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule